// File: doc/BRIEF.md
# Stack-Top Function Unit

A purely combinational operation unit for a data-stack processor. It reads the two uppermost stack entries (the top, T, and the entry beneath it, N) and a 16-bit opcode. It produces the value that becomes the new top of stack. It also produces a flag that tells the surrounding stack control whether N was used up, so the stack shrinks by one, or whether only T is replaced.

The opcode space follows a fixed Forth-style map. It covers the following groups:
- add and subtract
- increment and decrement
- bitwise logic
- single-step and variable shifts
- two constant generators
- a set of signed and unsigned relational tests

Relational results are full-width masks: all ones for true and zero for false. They can feed bitwise logic directly.

Two-operand operations always compute N op T. The stack control registers the result and moves the pointers.

Top module: `stk_fu`

## Requirements
- R1: Opcode 0x0010 gives N+T and 0x0011 gives N-T. Opcode 0x0012 gives T+1 and 0x0013 gives T-1. All results wrap modulo 2^16.
- R2: Opcode 0x0014 gives the bitwise complement of T. Opcode 0x0015 gives N AND T, 0x0016 gives N OR T, and 0x0017 gives N XOR T.
- R3: Opcode 0x0018 shifts T left by one and fills bit 0 with zero. Opcode 0x0019 shifts T right by one and fills bit 15 with zero. Opcode 0x001A shifts T right by one and copies bit 15 into bit 15.
- R4: Opcode 0x001B gives N shifted right logically by T places. Opcode 0x001C gives N shifted left by T places. Any T of 16 or more gives zero.
- R5: Opcode 0x0020 gives 0xFFFF and opcode 0x0021 gives 0x0000, whatever the operands are.
- R6: Opcode 0x0022 tests whether T equals zero. Opcode 0x0023 tests whether T is negative, meaning bit 15 is set. The result is 0xFFFF if the test is true and 0x0000 if it is false.
- R7: These unsigned tests on N against T give 0xFFFF if true and 0x0000 if false:
  - 0x0024 tests N>T
  - 0x0025 tests N<T
  - 0x0027 tests N>=T
  - 0x0028 tests N<=T
- R8: Opcode 0x0026 tests N==T and opcode 0x0029 tests N!=T. The result is 0xFFFF if true and 0x0000 if false.
- R9: These two's-complement tests on N against T give 0xFFFF if true and 0x0000 if false:
  - 0x002A tests N>T
  - 0x002B tests N<T
  - 0x002C tests N>=T
  - 0x002D tests N<=T
- R10: binary_o is high exactly for these opcodes, which consume N:
  - 0x0010 and 0x0011
  - 0x0015 to 0x0017
  - 0x001B and 0x001C
  - 0x0024 to 0x002D
  
  It is low for every other opcode, including 0x0020 and 0x0021.
- R11: Any opcode not listed above, including 0x0000 and any opcode with bits above bit 5 set, passes T to the result unchanged with binary_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 16 | Operation code |
| t_i | input | DATA_W (16) | Current top of stack |
| n_i | input | DATA_W (16) | Entry under the top |
| t_o | output | DATA_W (16) | New top-of-stack value |
| binary_o | output | 1 | High when the operation consumes N |

## Verification
The bench builds the unit with its default DATA_W of 16, which matches the opcode map's word width. At this width, shift counts of 15, 16 and 17 and the sign-bit boundary at 0x7FFF/0x8000 are all within reach of the directed vectors. Random operands are drawn against every defined opcode and against random undefined opcodes, so the pass-through path and the flag are covered alongside each function group.

// File: rtl/stk_fu_pkg.sv
package stk_fu_pkg;
  localparam int OP_W = 16;
  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_ADD  = 16'h0010;
  localparam op_t OP_SUB  = 16'h0011;
  localparam op_t OP_INC  = 16'h0012;
  localparam op_t OP_DEC  = 16'h0013;
  localparam op_t OP_NOT  = 16'h0014;
  localparam op_t OP_AND  = 16'h0015;
  localparam op_t OP_OR   = 16'h0016;
  localparam op_t OP_XOR  = 16'h0017;
  localparam op_t OP_SHL1 = 16'h0018;
  localparam op_t OP_LSR1 = 16'h0019;
  localparam op_t OP_ASR1 = 16'h001A;
  localparam op_t OP_RSH  = 16'h001B;
  localparam op_t OP_LSH  = 16'h001C;
  localparam op_t OP_ONES = 16'h0020;
  localparam op_t OP_ZERO = 16'h0021;
  localparam op_t OP_ZEQ  = 16'h0022;
  localparam op_t OP_ZLT  = 16'h0023;
  localparam op_t OP_UGT  = 16'h0024;
  localparam op_t OP_ULT  = 16'h0025;
  localparam op_t OP_EQ   = 16'h0026;
  localparam op_t OP_UGE  = 16'h0027;
  localparam op_t OP_ULE  = 16'h0028;
  localparam op_t OP_NE   = 16'h0029;
  localparam op_t OP_SGT  = 16'h002A;
  localparam op_t OP_SLT  = 16'h002B;
  localparam op_t OP_SGE  = 16'h002C;
  localparam op_t OP_SLE  = 16'h002D;

  typedef enum logic [3:0] {
    FU_PASS, FU_ADD, FU_SUB, FU_INC, FU_DEC, FU_NOT, FU_AND, FU_OR,
    FU_XOR, FU_SHL1, FU_LSR1, FU_ASR1, FU_ONES, FU_ZERO, FU_SHIFT, FU_CMP
  } fu_sel_e;

  typedef enum logic [3:0] {
    CMP_ZEQ, CMP_ZLT, CMP_UGT, CMP_ULT, CMP_EQ, CMP_UGE,
    CMP_ULE, CMP_NE, CMP_SGT, CMP_SLT, CMP_SGE, CMP_SLE
  } cmp_sel_e;
endpackage

// File: rtl/stk_fu_decode.sv
module stk_fu_decode
  import stk_fu_pkg::*;
(
  input  op_t      opcode_i,
  output fu_sel_e  fu_sel_o,
  output cmp_sel_e cmp_sel_o,
  output logic     shift_left_o,
  output logic     binary_o
);
  always_comb begin
    fu_sel_o     = FU_PASS;
    cmp_sel_o    = CMP_EQ;
    shift_left_o = 1'b0;
    binary_o     = 1'b0;
    case (opcode_i)
      OP_ADD:  begin fu_sel_o = FU_ADD; binary_o = 1'b1; end
      OP_SUB:  begin fu_sel_o = FU_SUB; binary_o = 1'b1; end
      OP_INC:  fu_sel_o = FU_INC;
      OP_DEC:  fu_sel_o = FU_DEC;
      OP_NOT:  fu_sel_o = FU_NOT;
      OP_AND:  begin fu_sel_o = FU_AND; binary_o = 1'b1; end
      OP_OR:   begin fu_sel_o = FU_OR;  binary_o = 1'b1; end
      OP_XOR:  begin fu_sel_o = FU_XOR; binary_o = 1'b1; end
      OP_SHL1: fu_sel_o = FU_SHL1;
      OP_LSR1: fu_sel_o = FU_LSR1;
      OP_ASR1: fu_sel_o = FU_ASR1;
      OP_RSH:  begin fu_sel_o = FU_SHIFT; binary_o = 1'b1; end
      OP_LSH:  begin fu_sel_o = FU_SHIFT; shift_left_o = 1'b1; binary_o = 1'b1; end
      OP_ONES: fu_sel_o = FU_ONES;
      OP_ZERO: fu_sel_o = FU_ZERO;
      OP_ZEQ:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_ZEQ; end
      OP_ZLT:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_ZLT; end
      OP_UGT:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_UGT; binary_o = 1'b1; end
      OP_ULT:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_ULT; binary_o = 1'b1; end
      OP_EQ:   begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_EQ;  binary_o = 1'b1; end
      OP_UGE:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_UGE; binary_o = 1'b1; end
      OP_ULE:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_ULE; binary_o = 1'b1; end
      OP_NE:   begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_NE;  binary_o = 1'b1; end
      OP_SGT:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_SGT; binary_o = 1'b1; end
      OP_SLT:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_SLT; binary_o = 1'b1; end
      OP_SGE:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_SGE; binary_o = 1'b1; end
      OP_SLE:  begin fu_sel_o = FU_CMP; cmp_sel_o = CMP_SLE; binary_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_fu_alu.sv
module stk_fu_alu
  import stk_fu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  fu_sel_e           sel_i,
  input  logic [DATA_W-1:0] t_i,
  input  logic [DATA_W-1:0] n_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (sel_i)
      FU_ADD:  res_o = n_i + t_i;
      FU_SUB:  res_o = n_i - t_i;
      FU_INC:  res_o = t_i + ONE;
      FU_DEC:  res_o = t_i - ONE;
      FU_NOT:  res_o = ~t_i;
      FU_AND:  res_o = n_i & t_i;
      FU_OR:   res_o = n_i | t_i;
      FU_XOR:  res_o = n_i ^ t_i;
      FU_SHL1: res_o = {t_i[DATA_W-2:0], 1'b0};
      FU_LSR1: res_o = {1'b0, t_i[DATA_W-1:1]};
      FU_ASR1: res_o = {t_i[DATA_W-1], t_i[DATA_W-1:1]};
      FU_ONES: res_o = '1;
      FU_ZERO: res_o = '0;
      default: res_o = t_i;
    endcase
  end
endmodule

// File: rtl/stk_fu_shift.sv
module stk_fu_shift #(
  parameter int DATA_W = 16
) (
  input  logic              left_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] n_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] CNT_LIM = DATA_W'(DATA_W);

  logic             cnt_big;
  logic [CNT_W-1:0] amt;

  assign cnt_big = (cnt_i >= CNT_LIM);
  assign amt     = cnt_i[CNT_W-1:0];

  always_comb begin
    if (cnt_big)     res_o = '0;
    else if (left_i) res_o = n_i << amt;
    else             res_o = n_i >> amt;
  end
endmodule

// File: rtl/stk_fu_cmp.sv
module stk_fu_cmp
  import stk_fu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cmp_sel_e          sel_i,
  input  logic [DATA_W-1:0] t_i,
  input  logic [DATA_W-1:0] n_i,
  output logic [DATA_W-1:0] mask_o
);
  logic hit;

  always_comb begin
    case (sel_i)
      CMP_ZEQ: hit = (t_i == '0);
      CMP_ZLT: hit = t_i[DATA_W-1];
      CMP_UGT: hit = (n_i >  t_i);
      CMP_ULT: hit = (n_i <  t_i);
      CMP_EQ:  hit = (n_i == t_i);
      CMP_UGE: hit = (n_i >= t_i);
      CMP_ULE: hit = (n_i <= t_i);
      CMP_NE:  hit = (n_i != t_i);
      CMP_SGT: hit = ($signed(n_i) >  $signed(t_i));
      CMP_SLT: hit = ($signed(n_i) <  $signed(t_i));
      CMP_SGE: hit = ($signed(n_i) >= $signed(t_i));
      CMP_SLE: hit = ($signed(n_i) <= $signed(t_i));
      default: hit = 1'b0;
    endcase
    mask_o = {DATA_W{hit}};
  end
endmodule

// File: rtl/stk_fu.sv
module stk_fu
  import stk_fu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] t_i,
  input  logic [DATA_W-1:0] n_i,
  output logic [DATA_W-1:0] t_o,
  output logic              binary_o
);
  localparam logic [DATA_W-1:0] CNT_LIM = DATA_W'(DATA_W);

  fu_sel_e           fu_sel;
  cmp_sel_e          cmp_sel;
  logic              shift_left;
  logic [DATA_W-1:0] alu_res, sh_res, cmp_res;

  stk_fu_decode i_dec (
    .opcode_i     (opcode_i),
    .fu_sel_o     (fu_sel),
    .cmp_sel_o    (cmp_sel),
    .shift_left_o (shift_left),
    .binary_o     (binary_o)
  );

  stk_fu_alu #(.DATA_W(DATA_W)) i_alu (
    .sel_i (fu_sel), .t_i (t_i), .n_i (n_i), .res_o (alu_res)
  );

  stk_fu_shift #(.DATA_W(DATA_W)) i_sh (
    .left_i (shift_left), .cnt_i (t_i), .n_i (n_i), .res_o (sh_res)
  );

  stk_fu_cmp #(.DATA_W(DATA_W)) i_cmp (
    .sel_i (cmp_sel), .t_i (t_i), .n_i (n_i), .mask_o (cmp_res)
  );

  always_comb begin
    case (fu_sel)
      FU_SHIFT: t_o = sh_res;
      FU_CMP:   t_o = cmp_res;
      default:  t_o = alu_res;
    endcase
  end

  always_comb begin
    if (opcode_i >= OP_ZEQ && opcode_i <= OP_SLE)
      AST_CMP_MASK: assert (t_o == '0 || t_o == '1) else $error("compare not a mask"); // R6
    if ((opcode_i == OP_RSH || opcode_i == OP_LSH) && t_i >= CNT_LIM)
      AST_SHIFT_SAT: assert (t_o == '0) else $error("oversized shift not zero"); // R4
    if (opcode_i == OP_ONES)
      AST_ONES_CONST: assert (t_o == '1 && !binary_o) else $error("TRUE wrong"); // R5
    if (binary_o)
      AST_BIN_KNOWN: assert (opcode_i[15:6] == '0 && opcode_i[5:4] != 2'b00) else $error("flag on bad op"); // R10
    if (opcode_i[15:6] != '0 || opcode_i[5:4] == 2'b00)
      AST_UNKNOWN_PASS: assert (t_o == t_i && !binary_o) else $error("unknown op not passed"); // R11
  end
endmodule

// File: tb/test_stk_fu.sv
module test_stk_fu;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [15:0]   opcode;
  logic [DW-1:0] t_val, n_val, t_res;
  logic          bin_res;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  stk_fu #(.DATA_W(DW)) i_stk_fu (
    .opcode_i (opcode), .t_i (t_val), .n_i (n_val),
    .t_o (t_res), .binary_o (bin_res)
  );

  function automatic logic [16:0] model(input logic [15:0] op, input logic [15:0] n, input logic [15:0] t);
    logic [15:0] r;
    logic b;
    b = 1'b0;
    r = t;
    case (op)
      16'h0010: begin r = n + t; b = 1; end
      16'h0011: begin r = n - t; b = 1; end
      16'h0012: r = t + 16'd1;
      16'h0013: r = t - 16'd1;
      16'h0014: r = ~t;
      16'h0015: begin r = n & t; b = 1; end
      16'h0016: begin r = n | t; b = 1; end
      16'h0017: begin r = n ^ t; b = 1; end
      16'h0018: r = {t[14:0], 1'b0};
      16'h0019: r = {1'b0, t[15:1]};
      16'h001A: r = {t[15], t[15:1]};
      16'h001B: begin b = 1; r = 16'h0; for (int i = 0; i < 16; i++) if (32'(t) + i < 16) r[i] = n[i + int'(t)]; end
      16'h001C: begin b = 1; r = 16'h0; for (int i = 0; i < 16; i++) if (i >= int'(t)) r[i] = n[i - int'(t)]; end
      16'h0020: r = 16'hFFFF;
      16'h0021: r = 16'h0000;
      16'h0022: r = (t == 0) ? 16'hFFFF : 16'h0;
      16'h0023: r = t[15] ? 16'hFFFF : 16'h0;
      16'h0024: begin b = 1; r = (n > t) ? 16'hFFFF : 16'h0; end
      16'h0025: begin b = 1; r = (n < t) ? 16'hFFFF : 16'h0; end
      16'h0026: begin b = 1; r = (n == t) ? 16'hFFFF : 16'h0; end
      16'h0027: begin b = 1; r = (n >= t) ? 16'hFFFF : 16'h0; end
      16'h0028: begin b = 1; r = (n <= t) ? 16'hFFFF : 16'h0; end
      16'h0029: begin b = 1; r = (n != t) ? 16'hFFFF : 16'h0; end
      16'h002A: begin b = 1; r = ($signed(n) > $signed(t)) ? 16'hFFFF : 16'h0; end
      16'h002B: begin b = 1; r = ($signed(n) < $signed(t)) ? 16'hFFFF : 16'h0; end
      16'h002C: begin b = 1; r = ($signed(n) >= $signed(t)) ? 16'hFFFF : 16'h0; end
      16'h002D: begin b = 1; r = ($signed(n) <= $signed(t)) ? 16'hFFFF : 16'h0; end
      default: ;
    endcase
    return {b, r};
  endfunction

  function automatic string req_of(input logic [15:0] op);
    if (op >= 16'h0010 && op <= 16'h0013) return "R1";
    if (op >= 16'h0014 && op <= 16'h0017) return "R2";
    if (op >= 16'h0018 && op <= 16'h001A) return "R3";
    if (op == 16'h001B || op == 16'h001C) return "R4";
    if (op == 16'h0020 || op == 16'h0021) return "R5";
    if (op == 16'h0022 || op == 16'h0023) return "R6";
    if (op == 16'h0026 || op == 16'h0029) return "R8";
    if (op >= 16'h0024 && op <= 16'h0028) return "R7";
    if (op >= 16'h002A && op <= 16'h002D) return "R9";
    return "R11";
  endfunction

  task automatic apply(input logic [15:0] op, input logic [15:0] n, input logic [15:0] t);
    logic [16:0] exp;
    @(posedge clk);
    opcode = op; n_val = n; t_val = t;
    @(negedge clk);
    exp = model(op, n, t);
    n_vec++;
    if (t_res !== exp[15:0]) begin
      n_bad++;
      $display("FAIL %s op=%h n=%h t=%h result actual=%h expected=%h", req_of(op), op, n, t, t_res, exp[15:0]);
    end
    if (bin_res !== exp[16]) begin
      n_bad++;
      $display("FAIL R10 op=%h binary_o actual=%b expected=%b", op, bin_res, exp[16]);
    end
  endtask

  logic [15:0] known_ops [30];
  logic [15:0] corner [8];

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0404;
    void'($urandom(seed));
    opcode = '0; n_val = '0; t_val = '0;
    for (int i = 0; i < 13; i++) known_ops[i] = 16'h0010 + 16'(i);
    known_ops[13] = 16'h0020; known_ops[14] = 16'h0021;
    for (int i = 0; i < 12; i++) known_ops[15 + i] = 16'h0022 + 16'(i);
    known_ops[27] = 16'h0000; known_ops[28] = 16'h0110; known_ops[29] = 16'h001F;
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF; corner[3] = 16'h8000;
    corner[4] = 16'hFFFF; corner[5] = 16'd15;   corner[6] = 16'd16;   corner[7] = 16'd17;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: nop opcode passes T=0, flag low (R11)
    apply(16'h0000, 16'h0000, 16'h0000);
    // directed corners over every defined op (R1..R10)
    foreach (known_ops[k])
      foreach (corner[a])
        foreach (corner[b])
          apply(known_ops[k], corner[a], corner[b]);
    // shift boundary R4
    apply(16'h001B, 16'h8000, 16'd15);
    apply(16'h001C, 16'h0001, 16'd15);
    apply(16'h001C, 16'hFFFF, 16'd16);
    apply(16'h001B, 16'hFFFF, 16'h0100);
    // random stimulus, defined and undefined opcodes
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] op;
      if ($urandom_range(0, 4) == 0) op = 16'($urandom);
      else op = known_ops[$urandom_range(0, 29)];
      apply(op, 16'($urandom), ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 20)) : 16'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule